// File: doc/BRIEF.md
# Weighted Lottery Bus Arbiter

This block chooses one bus master at a time from up to `N` requesters. Each master has a programmable ticket count that sets its weight. On a draw, only the masters that are requesting put their tickets into the pool. A free-running pseudo-random value, reduced into the range of the pooled tickets, picks the winner. A master's chance of winning is therefore its share of the pooled tickets, not its turn in a rotation.

Ticket counts are loaded through a one-cycle write port. A draw happens on a clock edge where the arbitration strobe is high and the bus is not busy. The result is held in a registered one-hot grant with a valid flag. The grant stays unchanged until the next accepted draw.

Top module: `lottery_arbiter`

## Requirements
- R1: Every ticket count resets to 1. A cycle with `wr_en` high stores `wr_tickets` into the count of master `wr_idx`, and that count applies from the next draw onward.
- R2: Only a master whose `req` bit is high at the draw and whose ticket count is nonzero can receive the grant.
- R3: `grant` has at most one bit set, and `grant_valid` is high exactly when one bit of `grant` is set.
- R4: A draw with no request, or with an active ticket sum of zero, leaves `grant` all zeros and `grant_valid` low.
- R5: A draw takes place on a rising edge where `arb_strobe` is 1 and `bus_busy` is 0. Its result appears on `grant` and `grant_valid` right after that edge.
- R6: On an edge where `bus_busy` is 1 or `arb_strobe` is 0, `grant` and `grant_valid` keep their values, whatever `req` does.
- R7: Active masters own back-to-back slices of [0, S), where S is the sum of their tickets. The slices are placed in ascending master index, and each slice is as wide as that master's ticket count. Over many draws, the grant counts therefore follow the ticket ratios.
- R8: After reset, `grant` is all zeros and `grant_valid` is low.
- R9: A lone eligible requester wins every draw.
- R10: The random source is a maximal-length LFSR wider than the sum. It advances every cycle and never holds zero. The draw value is the LFSR value modulo S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N | Request bit of each master |
| arb_strobe | input | 1 | Asks for a draw on this edge |
| bus_busy | input | 1 | Bus in use; blocks any draw |
| wr_en | input | 1 | Ticket write enable |
| wr_idx | input | IDX_W | Master whose ticket count is written |
| wr_tickets | input | TICKET_W | New ticket count |
| grant | output | N | Registered one-hot grant |
| grant_valid | output | 1 | A grant is held |

## Verification
A corrupted prefix sum or slice bound would not show up as an illegal grant. It shows up as a skew in the winners: a master with zero tickets would sometimes win, or the grant frequencies would drift from the ticket ratio. The bench therefore compares counts over hundreds of draws. A broken hold path or a stale eligibility mask shows up one cycle after the offending edge, as a changed or ineligible `grant`. A stuck LFSR collapses every draw to a single slice, and the ratio check catches that within the first few hundred draws.

// File: rtl/lottery_arbiter.sv
module lottery_arbiter #(
  parameter int N          = 4,
  parameter int TICKET_W   = 4,
  parameter int LFSR_W     = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int IDX_W     = (N > 1) ? $clog2(N) : 1,
  localparam int SUM_W     = TICKET_W + $clog2(N + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        req,
  input  logic                arb_strobe,
  input  logic                bus_busy,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [TICKET_W-1:0] wr_tickets,
  output logic [N-1:0]        grant,
  output logic                grant_valid
);

  logic [TICKET_W-1:0] tix [N];
  logic [LFSR_W-1:0]   lfsr;
  logic [SUM_W-1:0]    act [N];
  logic [SUM_W-1:0]    lo  [N];
  logic [SUM_W-1:0]    total;
  logic [LFSR_W-1:0]   draw_full;
  logic [SUM_W-1:0]    draw;
  logic [N-1:0]        win;
  logic                fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) tix[i] <= TICKET_W'(1);
    end else if (wr_en) begin
      for (int i = 0; i < N; i++)
        if (wr_idx == IDX_W'(i)) tix[i] <= wr_tickets;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= LFSR_SEED;
    else        lfsr <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? LFSR_TAPS : '0);
  end

  always_comb begin
    logic [SUM_W-1:0] run;
    run = '0;
    for (int i = 0; i < N; i++) begin
      act[i] = req[i] ? SUM_W'(tix[i]) : '0;
      lo[i]  = run;
      run    = run + act[i];
    end
    total = run;
  end

  assign draw_full = (total == '0) ? '0 : (lfsr % LFSR_W'(total));
  assign draw      = draw_full[SUM_W-1:0];

  for (genvar g = 0; g < N; g++) begin : g_slice
    logic [SUM_W-1:0] hi;
    assign hi     = lo[g] + act[g];
    assign win[g] = (act[g] != '0) && (draw >= lo[g]) && (draw < hi);
  end

  assign fire = arb_strobe && !bus_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant       <= '0;
      grant_valid <= 1'b0;
    end else if (fire) begin
      grant       <= win;
      grant_valid <= |win;
    end
  end

endmodule

module lottery_arbiter_chk #(
  parameter int N      = 4,
  parameter int LFSR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      req,
  input logic              arb_strobe,
  input logic              bus_busy,
  input logic [N-1:0]      grant,
  input logic              grant_valid,
  input logic [LFSR_W-1:0] lfsr
);

  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r3_valid_matches: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (grant != '0));

  a_r2_only_requesters: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_strobe && !bus_busy) |=> ((grant & ~$past(req)) == '0));

  a_r4_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_strobe && !bus_busy && req == '0) |=> !grant_valid);

  a_r6_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy || !arb_strobe) |=> ($stable(grant) && $stable(grant_valid)));

  a_r10_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

endmodule

bind lottery_arbiter lottery_arbiter_chk #(.N(N), .LFSR_W(LFSR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .arb_strobe(arb_strobe),
  .bus_busy(bus_busy), .grant(grant), .grant_valid(grant_valid), .lfsr(lfsr)
);

// File: tb/lottery_arbiter_test.sv
module lottery_arbiter_test;
  localparam int N = 4;
  localparam int TW = 4;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0;
  logic arb_strobe = 0, bus_busy = 0, wr_en = 0;
  logic [1:0] wr_idx = '0;
  logic [TW-1:0] wr_tickets = '0;
  logic [N-1:0] grant;
  logic grant_valid;

  int checks = 0, fails = 0;
  int tix_m [N];

  always #10 clk = ~clk;

  lottery_arbiter #(.N(N), .TICKET_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .arb_strobe(arb_strobe),
    .bus_busy(bus_busy), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_tickets(wr_tickets), .grant(grant), .grant_valid(grant_valid));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic logic [N-1:0] eligible(input logic [N-1:0] r);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = r[i] && (tix_m[i] != 0);
    return m;
  endfunction

  task automatic write_t(input int idx, input int val);
    @(negedge clk);
    wr_en = 1; wr_idx = 2'(idx); wr_tickets = TW'(val);
    @(negedge clk);
    wr_en = 0;
    tix_m[idx] = val;
  endtask

  task automatic draw(input logic [N-1:0] r);
    @(negedge clk);
    req = r; arb_strobe = 1; bus_busy = 0;
    @(negedge clk);
    arb_strobe = 0;
  endtask

  task automatic check_legal(input logic [N-1:0] r, input string tag);
    logic [N-1:0] m;
    m = eligible(r);
    if (m == '0)
      chk(grant == '0 && !grant_valid, {tag, " R4 empty pool"}, int'(grant), 0);
    else
      chk($onehot(grant) && grant_valid && ((grant & ~m) == '0),
          {tag, " R2/R3 legal grant"}, int'(grant), int'(m));
  endtask

  initial begin
    #(20 * 200000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [N-1:0] held;
    int cnt [N];
    void'($urandom(1234));
    for (int i = 0; i < N; i++) tix_m[i] = 1;
    repeat (3) @(negedge clk);
    chk(grant == '0 && !grant_valid, "R8 reset state", int'(grant), 0);
    rst_n = 1;

    // R1/R9: default tickets of 1, lone requester wins
    for (int i = 0; i < N; i++) begin
      draw(N'(1) << i);
      chk(grant == (N'(1) << i) && grant_valid, "R1 R9 lone default winner",
          int'(grant), 1 << i);
    end

    // R1/R4: writing zero tickets removes the lone requester
    write_t(2, 0);
    draw(4'b0100);
    chk(grant == '0 && !grant_valid, "R1 R4 zero tickets", int'(grant), 0);
    draw(4'b0000);
    chk(grant == '0 && !grant_valid, "R4 no request", int'(grant), 0);

    // R5: a result appears right after the accepted edge
    draw(4'b1000);
    chk(grant == 4'b1000, "R5 draw latency", int'(grant), 8);

    // R6: hold while busy, and while the strobe is low
    held = grant;
    @(negedge clk); req = 4'b0001; arb_strobe = 1; bus_busy = 1;
    repeat (3) @(negedge clk);
    chk(grant == held && grant_valid, "R6 hold while busy", int'(grant), int'(held));
    bus_busy = 0; arb_strobe = 0;
    repeat (2) @(negedge clk);
    chk(grant == held, "R6 hold without strobe", int'(grant), int'(held));

    // R7/R10: frequency against ticket ratio 1:3:4:0
    write_t(0, 1); write_t(1, 3); write_t(2, 4); write_t(3, 0);
    for (int i = 0; i < N; i++) cnt[i] = 0;
    for (int k = 0; k < 800; k++) begin
      draw(4'b1111);
      for (int i = 0; i < N; i++) if (grant[i]) cnt[i]++;
    end
    chk(cnt[3] == 0, "R2 zero-ticket master never wins", cnt[3], 0);
    chk(cnt[0] > 40 && cnt[0] < 160, "R7 R10 share of 1/8", cnt[0], 100);
    chk(cnt[1] > 240 && cnt[1] < 360, "R7 R10 share of 3/8", cnt[1], 300);
    chk(cnt[2] > 340 && cnt[2] < 460, "R7 share of 4/8", cnt[2], 400);

    // R7: ignoring a non-requester re-weights the pool (1:4 between M0 and M2)
    for (int i = 0; i < N; i++) cnt[i] = 0;
    for (int k = 0; k < 500; k++) begin
      draw(4'b0101);
      for (int i = 0; i < N; i++) if (grant[i]) cnt[i]++;
    end
    chk(cnt[1] == 0 && cnt[3] == 0, "R7 non-requesters get no slice", cnt[1] + cnt[3], 0);
    chk(cnt[0] > 60 && cnt[0] < 140, "R7 share of 1/5", cnt[0], 100);

    // Constrained random: tickets, requests, busy, strobe
    for (int k = 0; k < 300; k++) begin
      logic [N-1:0] r;
      if ($urandom_range(0, 9) == 0) write_t($urandom_range(0, N - 1), $urandom_range(0, 3));
      r = N'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        held = grant;
        @(negedge clk); req = r; arb_strobe = 1; bus_busy = 1;
        @(negedge clk); arb_strobe = 0; bus_busy = 0;
        chk(grant == held, "R6 random busy hold", int'(grant), int'(held));
      end else begin
        draw(r);
        check_legal(r, "random");
        if ($onehot(eligible(r)))
          chk(grant == eligible(r), "R9 random lone eligible", int'(grant), int'(eligible(r)));
      end
    end

    finish_run();
  end
endmodule